// File: doc/BRIEF.md
# Streaming Euclidean GCD Engine

This block takes pairs of unsigned 32-bit operands from a producer and returns their greatest common divisor to a consumer. Both sides use a valid/ready handshake. A two-entry queue buffers operand pairs on the way in. A two-entry queue buffers results on the way out. Between the two queues sits one iterative core.

The core uses only three kinds of step: compare, subtract and exchange. In each cycle, if x is at least y, x becomes x minus y. Otherwise, if x is nonzero, x and y swap values. The computation is complete once x reaches zero, and the answer is then in y.

A pair moves from the input queue into the core only when the core is idle. A finished answer moves into the output queue only when that queue has room. The core then returns to idle. A pair whose second operand is zero would never terminate, so it is not iterated. Its first operand is returned at once, with a flag set.

Top module: `gcd_stream`

## Requirements
- R1: After a synchronous active-high reset, out_valid is low and in_ready is high. Both queues are empty and the core is idle.
- R2: For a pair whose second operand is nonzero, the result equals the greatest common divisor of the two operands and out_bzero is 0. During a computation, the core's y register never increases.
- R3: For a pair whose second operand is zero, the result equals the first operand and out_bzero is 1.
- R4: For a pair whose first operand is zero and whose second operand is nonzero, the result equals the second operand.
- R5: Results leave in the order in which their pairs were accepted.
- R6: Each queue holds two entries. With out_ready held low, the block accepts exactly five pairs and then drives in_ready low: two in the output queue, one in the core and two in the input queue.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_result and out_bzero stay unchanged.
- R8: A pair is launched into the core only while the core is idle. The core is busy in the cycle after a launch.
- R9: A result is retired into the output queue only when the core is complete and the output queue is not full. The core stays busy until that happens and is idle in the cycle after it.
- R10: A pair transfers only on a clock edge where in_valid and in_ready are both high. A pair offered while in_ready is low is neither stored nor returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Input queue has room |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Greatest common divisor, or the first operand when the second operand is zero |
| out_bzero | output | 1 | Set when the second operand of the pair was zero |

## Verification
The assertions check, on every cycle, the following properties:
- Output stability under back-pressure.
- The reset state of the handshake outputs.
- That a launch always leaves the core busy.
- That retirement frees the core and never happens before completion.
- That y does not grow while a computation runs.

The correctness of each answer, the zero-operand rules, result ordering and the exact five-pair capacity can only be shown by the bench scenarios. These compare the outputs against a software GCD over table pairs, scaled random pairs and a fully stalled fill-and-drain.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

    localparam int unsigned OPW = 32;

    typedef logic [OPW-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
    } pair_t;

    typedef struct packed {
        logic  bzero;
        word_t value;
    } result_t;

    typedef enum logic {
        CORE_IDLE = 1'b0,
        CORE_RUN  = 1'b1
    } core_state_e;

    localparam int unsigned PAIR_W = $bits(pair_t);
    localparam int unsigned RES_W  = $bits(result_t);

    function automatic logic sub_step(word_t x, word_t y);
        return x >= y;
    endfunction

endpackage

// File: rtl/gcd_queue.sv
module gcd_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/gcd_core.sv
module gcd_core
    import gcd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  pair_t   load_pair,
    input  logic    take,
    output logic    busy,
    output logic    done,
    output result_t res
);
    core_state_e state;
    word_t       x, y;
    logic        bzero;

    assign busy      = (state == CORE_RUN);
    assign done      = busy && (x == '0);
    assign res.value = y;
    assign res.bzero = bzero;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CORE_IDLE;
            x     <= '0;
            y     <= '0;
            bzero <= 1'b0;
        end else if (load) begin
            state <= CORE_RUN;
            if (load_pair.b == '0) begin
                // would never terminate: answer with the first operand at once
                x     <= '0;
                y     <= load_pair.a;
                bzero <= 1'b1;
            end else begin
                x     <= load_pair.a;
                y     <= load_pair.b;
                bzero <= 1'b0;
            end
        end else if (take) begin
            state <= CORE_IDLE;
        end else if (busy && x != '0) begin
            if (sub_step(x, y)) begin
                x <= x - y;
            end else begin
                x <= y;
                y <= x;
            end
        end
    end
endmodule

// File: rtl/gcd_stream.sv
module gcd_stream
    import gcd_pkg::*;
#(
    parameter int QDEPTH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_a,
    input  logic [31:0] in_b,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_result,
    output logic        out_bzero
);
    logic              inq_full, inq_empty;
    logic              outq_full, outq_empty;
    logic [PAIR_W-1:0] inq_head;
    logic [RES_W-1:0]  outq_head;
    pair_t             in_pair, head_pair;
    result_t           core_res, out_res;
    logic              core_busy, core_done;
    logic              launch, retire;

    assign in_pair.a = in_a;
    assign in_pair.b = in_b;
    assign head_pair = inq_head;
    assign out_res   = outq_head;

    assign launch = !inq_empty && !core_busy;
    assign retire = core_done && !outq_full;

    gcd_queue #(.W(PAIR_W), .DEPTH(QDEPTH)) u_inq (
        .clk   (clk),
        .rst   (rst),
        .push  (in_valid),
        .din   (in_pair),
        .full  (inq_full),
        .pop   (launch),
        .dout  (inq_head),
        .empty (inq_empty)
    );

    gcd_core u_core (
        .clk       (clk),
        .rst       (rst),
        .load      (launch),
        .load_pair (head_pair),
        .take      (retire),
        .busy      (core_busy),
        .done      (core_done),
        .res       (core_res)
    );

    gcd_queue #(.W(RES_W), .DEPTH(QDEPTH)) u_outq (
        .clk   (clk),
        .rst   (rst),
        .push  (retire),
        .din   (core_res),
        .full  (outq_full),
        .pop   (out_ready),
        .dout  (outq_head),
        .empty (outq_empty)
    );

    assign in_ready   = !inq_full;
    assign out_valid  = !outq_empty;
    assign out_result = out_res.value;
    assign out_bzero  = out_res.bzero;
endmodule

// File: rtl/gcd_stream_chk.sv
module gcd_stream_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_result,
    input logic        out_bzero,
    input logic        launch,
    input logic        retire,
    input logic        core_busy,
    input logic        core_done,
    input logic [31:0] core_y
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_bzero)));

    // R8
    launch_busy_chk: assert property (@(posedge clk) disable iff (rst)
        launch |=> core_busy);

    // R9
    retire_free_chk: assert property (@(posedge clk) disable iff (rst)
        retire |=> !core_busy);

    // R9
    no_early_retire_chk: assert property (@(posedge clk) disable iff (rst)
        (core_busy && !core_done) |=> core_busy);

    // R2
    y_nonincr_chk: assert property (@(posedge clk) disable iff (rst)
        core_busy |=> (core_y <= $past(core_y)));
endmodule

bind gcd_stream gcd_stream_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result),
    .out_bzero  (out_bzero),
    .launch     (launch),
    .retire     (retire),
    .core_busy  (core_busy),
    .core_done  (core_done),
    .core_y     (core_res.value)
);

// File: tb/gcd_stream_tb.sv
module gcd_stream_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_result;
    logic        out_bzero;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    gcd_stream u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_result(out_result), .out_bzero(out_bzero)
    );

    // {a, b, expected result, expected zero flag}
    localparam int NV = 13;
    localparam logic [96:0] VEC [NV] = '{
        {32'd15,         32'd6,          32'd3,          1'b0},  // R2
        {32'd6,          32'd15,         32'd3,          1'b0},  // R2 swap first
        {32'd7,          32'd7,          32'd7,          1'b0},  // R2 equal operands
        {32'd1,          32'd9,          32'd1,          1'b0},  // R2 one operand 1
        {32'd9,          32'd1,          32'd1,          1'b0},  // R2
        {32'd0,          32'd5,          32'd5,          1'b0},  // R4
        {32'd12,         32'd0,          32'd12,         1'b1},  // R3
        {32'd0,          32'd0,          32'd0,          1'b1},  // R3 both zero
        {32'hFFFFFFFF,   32'hFFFFFFFF,   32'hFFFFFFFF,   1'b0},  // R2 largest
        {32'hFFFFFFFF,   32'h55555555,   32'h55555555,   1'b0},  // R2
        {32'h80000000,   32'h40000000,   32'h40000000,   1'b0},  // R2
        {32'd1000,       32'd375,        32'd125,        1'b0},  // R2
        {32'd17,         32'd13,         32'd1,          1'b0}   // R2 coprime
    };

    logic [31:0] qa [64];
    logic [31:0] qb [64];
    logic [31:0] qe [64];
    logic        qf [64];
    int          qn = 0;

    function automatic logic [31:0] sw_gcd(logic [31:0] a, logic [31:0] b);
        logic [31:0] p = a;
        logic [31:0] q = b;
        while (q != 0) begin
            logic [31:0] t = p % q;
            p = q;
            q = t;
        end
        return p;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_all();
        for (int i = 0; i < qn; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_a = qa[i];
            in_b = qb[i];
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic collect_all(int stall);
        int got = 0;
        int cyc = 0;
        while (got < qn) begin
            @(negedge clk);
            cyc++;
            out_ready = (stall == 0) ? 1'b1 : ((cyc % 3) != 0);
            if (out_valid && out_ready) begin
                string tag;
                tag = (qb[got] == 0) ? "R3 R5" : ((qa[got] == 0) ? "R4 R5" : "R2 R5");
                chk(out_result == qe[got], tag, out_result, qe[got]);
                chk(out_bzero == qf[got], {tag, " flag"}, 32'(out_bzero), 32'(qf[got]));
                got++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic run_batch(int stall);
        fork
            drive_all();
            collect_all(stall);
        join
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int accepted;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
        chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);

        // table vectors, free-running consumer
        qn = NV;
        for (int i = 0; i < NV; i++) begin
            qa[i] = VEC[i][96:65];
            qb[i] = VEC[i][64:33];
            qe[i] = VEC[i][32:1];
            qf[i] = VEC[i][0];
        end
        run_batch(0);
        // same table with a stalling consumer
        run_batch(1);

        // scaled random pairs: common factor keeps iteration count small
        qn = 24;
        for (int i = 0; i < 24; i++) begin
            logic [31:0] k, a, b;
            k = $urandom_range(4000000, 1);
            a = $urandom_range(1023, 1);
            b = $urandom_range(1023, 1);
            qa[i] = a * k;
            qb[i] = b * k;
            qe[i] = sw_gcd(a, b) * k;
            qf[i] = 1'b0;
        end
        run_batch(1);

        // R6 / R10 capacity with consumer stalled
        out_ready = 1'b0;
        accepted = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_a = 32'(30 * (accepted + 1));
            in_b = 32'(6 * (accepted + 1));
            if (in_ready) accepted++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(accepted == 5, "R6 accepted", 32'(accepted), 32'd5);
        chk(in_ready == 1'b0, "R6 in_ready", 32'(in_ready), 32'd0);
        // R7 output held under back-pressure
        held = out_result;
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b1, "R7 out_valid", 32'(out_valid), 32'd1);
        chk(out_result == held && held == 32'd6, "R7 out_result", out_result, 32'd6);
        qn = 5;
        for (int i = 0; i < 5; i++) begin
            qa[i] = 32'(30 * (i + 1));
            qb[i] = 32'(6 * (i + 1));
            qe[i] = 32'(6 * (i + 1));
            qf[i] = 1'b0;
        end
        collect_all(0);
        repeat (5) @(negedge clk);
        // R10 refused offers were not stored
        chk(out_valid == 1'b0, "R10 no extra result", 32'(out_valid), 32'd0);
        chk(in_ready == 1'b1, "R10 in_ready", 32'(in_ready), 32'd1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule